// File: doc/BRIEF.md
# Triggered PWM Timer Channel

This block is one 16-bit timer channel that drives a PWM output. Its count advances at a rate set by a power-of-two prescaler. The tick source is either the system clock or an external clock pin. The counter climbs to a programmable period value and then returns to zero.

Two trigger mechanisms gate the counting, one to start it and one to reset it. Each trigger can come from a software bit, from an external pin, or from either of the two. The polarity used on the pin is programmable separately for start and for reset. A mask bit can freeze the effect of both triggers.

The output has two modes. In pulse mode it is high while the count is below a compare value. In square mode it toggles each time the count wraps.

Software programs the channel through a simple byte-wide write port and reads the live count from a 16-bit output. Both external pins are asynchronous. Each passes through a two-flop synchronizer, and edges are detected in the system clock domain.

Top module: `pwm_trig_timer`

## Requirements
- R1: After reset, every configuration byte is 00h, the count is 0, the timer is stopped and `pwm_out` is low.
- R2: Register 0 holds the prescaler exponent P in bits [4:0] and the waveform select in bit 5. While the timer runs, the count advances once every 2^P ticks.
- R3: An exponent above 16 behaves exactly like 16, so the count advances once every 65536 ticks.
- R4: Register 1 bit 0 selects the tick. At 0, every system clock is a tick. At 1, only a rising edge of the synchronized `ext_clk` is a tick, and system clocks alone do not advance the count.
- R5: Register 1 bits [2:1] select the start source. The codes are: 00 for a rising edge of the software start bit (register 2 bit 0), 01 for a pin event, 10 for either, and 11 for the software bit only. An unselected source has no effect.
- R6: Register 1 bit 5 sets the start polarity on the pin. At 0, a rising edge of `ext_trig` starts the timer. At 1, a falling edge starts it.
- R7: Register 1 bits [4:3] select the reset source, using the same codes as the start source. The software reset bit is register 2 bit 1. A reset event clears the count and the prescaler phase to zero and stops the timer.
- R8: Register 1 bit 6 sets the reset polarity on the pin. At 0, a falling edge of `ext_trig` resets the timer. At 1, a rising edge resets it.
- R9: While register 1 bit 7 is 1, start and reset events are ignored. This holds whether the timer is running or stopped.
- R10: When a start event and a reset event fall in the same cycle, the reset wins and the timer ends up stopped at zero.
- R11: Registers 3/4 hold the period (low byte, high byte). When the count advances from a value at or above the period, it wraps to 0.
- R12: In pulse mode (waveform bit 0), `pwm_out` is high exactly when the count is below the compare value. The compare value is held in registers 5/6 (low byte, high byte).
- R13: In square mode (waveform bit 1), `pwm_out` inverts on every wrap and holds its value otherwise. A reset event returns it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| ext_clk | input | 1 | External tick source, asynchronous |
| ext_trig | input | 1 | External start/reset pin, asynchronous |
| pwm_out | output | 1 | PWM output |
| cnt_value | output | 16 | Current count |

## Verification
A start event and a reset event can land in the same clock cycle. The bench provokes this from a running timer with a single register write that raises both software bits at once. It then judges the result by the count: the count must read zero and stay at zero for many cycles afterwards, which shows that the timer stopped rather than restarted. A second collision is between a count advance and a wrap. Square mode makes this observable, because the output must flip on exactly the cycle the count goes from the period back to zero.

// File: rtl/pwm_trig_pkg.sv
package pwm_trig_pkg;

  localparam int PRESC_W   = 5;
  localparam int PRESC_MAX = 16;

  typedef enum logic [2:0] {
    A_MODE = 3'd0,
    A_TRIG = 3'd1,
    A_SW   = 3'd2,
    A_PER0 = 3'd3
  } cfg_addr_e;

  typedef struct packed {
    logic               mask;
    logic               rst_pol;
    logic               str_pol;
    logic [1:0]         rst_src;
    logic [1:0]         str_src;
    logic               clk_ext;
    logic               wave;
    logic [PRESC_W-1:0] presc;
    logic               sw_start;
    logic               sw_reset;
  } cfg_t;

  function automatic logic pick_src(input logic [1:0] src, input logic int_ev,
                                    input logic ext_ev);
    case (src)
      2'b01:   return ext_ev;
      2'b10:   return int_ev | ext_ev;
      default: return int_ev;
    endcase
  endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_trig_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output cfg_t              cfg,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  cmp
);

  localparam int NB       = CNT_W / 8;
  localparam int PER_BASE = int'(A_PER0);
  localparam int CMP_BASE = PER_BASE + NB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(A_MODE)) begin
        cfg.wave  <= wdata[5];
        cfg.presc <= wdata[PRESC_W-1:0];
      end
      if (addr == ADDR_W'(A_TRIG)) begin
        cfg.clk_ext <= wdata[0];
        cfg.str_src <= wdata[2:1];
        cfg.rst_src <= wdata[4:3];
        cfg.str_pol <= wdata[5];
        cfg.rst_pol <= wdata[6];
        cfg.mask    <= wdata[7];
      end
      if (addr == ADDR_W'(A_SW)) begin
        cfg.sw_start <= wdata[0];
        cfg.sw_reset <= wdata[1];
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        period[b*8 +: 8] <= '0;
        cmp[b*8 +: 8]    <= '0;
      end else if (we) begin
        if (addr == ADDR_W'(PER_BASE + b)) period[b*8 +: 8] <= wdata;
        if (addr == ADDR_W'(CMP_BASE + b)) cmp[b*8 +: 8]    <= wdata;
      end
    end
  end

endmodule

// File: rtl/pwm_pin_sync.sv
module pwm_pin_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] lvl_d
);

  logic [N-1:0] meta;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i]  <= 1'b0;
        lvl[i]   <= 1'b0;
        lvl_d[i] <= 1'b0;
      end else begin
        meta[i]  <= pin[i];
        lvl[i]   <= meta[i];
        lvl_d[i] <= lvl[i];
      end
    end
  end

endmodule

// File: rtl/pwm_trig_ctrl.sv
module pwm_trig_ctrl
  import pwm_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_start,
  input  logic       sw_reset,
  input  logic       mask,
  input  logic       str_pol,
  input  logic       rst_pol,
  input  logic [1:0] str_src,
  input  logic [1:0] rst_src,
  input  logic       pin_lvl,
  input  logic       pin_lvl_d,
  output logic       run,
  output logic       clr
);

  logic sw_start_q, sw_reset_q;
  logic pin_rise, pin_fall;
  logic int_start, int_rst, ext_start, ext_rst, start_ev;

  always_comb begin
    pin_rise  = pin_lvl & ~pin_lvl_d;
    pin_fall  = ~pin_lvl & pin_lvl_d;
    int_start = sw_start & ~sw_start_q;
    int_rst   = sw_reset & ~sw_reset_q;
    ext_start = str_pol ? pin_fall : pin_rise;
    ext_rst   = rst_pol ? pin_rise : pin_fall;
    start_ev  = ~mask & pick_src(str_src, int_start, ext_start);
    clr       = ~mask & pick_src(rst_src, int_rst, ext_rst);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_start_q <= 1'b0;
      sw_reset_q <= 1'b0;
      run        <= 1'b0;
    end else begin
      sw_start_q <= sw_start;
      sw_reset_q <= sw_reset;
      if (clr)           run <= 1'b0;
      else if (start_ev) run <= 1'b1;
    end
  end

endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
  import pwm_trig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               clr,
  input  logic [PRESC_W-1:0] presc,
  input  logic               wave,
  input  logic [CNT_W-1:0]   period,
  input  logic [CNT_W-1:0]   cmp,
  output logic [CNT_W-1:0]   cnt,
  output logic               pwm,
  output logic               adv,
  output logic               wrap
);

  localparam int PRE_W = PRESC_MAX;

  logic [PRESC_W-1:0] p_eff;
  logic [PRE_W:0]     one_sh;
  logic [PRE_W-1:0]   term;
  logic [PRE_W-1:0]   pre_q;
  logic               tog_q;

  always_comb begin
    p_eff  = (presc > PRESC_W'(PRESC_MAX)) ? PRESC_W'(PRESC_MAX) : presc;
    one_sh = {{PRE_W{1'b0}}, 1'b1} << p_eff;
    term   = PRE_W'(one_sh - 1'b1);
    adv    = tick & (pre_q >= term);
    wrap   = adv & (cnt >= period);
    pwm    = wave ? tog_q : (cnt < cmp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt   <= '0;
      tog_q <= 1'b0;
    end else if (clr) begin
      pre_q <= '0;
      cnt   <= '0;
      tog_q <= 1'b0;
    end else if (tick) begin
      pre_q <= adv ? '0 : pre_q + 1'b1;
      if (wrap) begin
        cnt   <= '0;
        tog_q <= ~tog_q;
      end else if (adv) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_trig_timer.sv
module pwm_trig_timer
  import pwm_trig_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int ADDR_W = $clog2(int'(A_PER0) + 2 * (CNT_W / 8))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              ext_clk,
  input  logic              ext_trig,
  output logic              pwm_out,
  output logic [CNT_W-1:0]  cnt_value
);

  cfg_t             cfg;
  logic [CNT_W-1:0] period, cmp;
  logic [1:0]       lvl, lvl_d;
  logic             run, clr, tick, adv, wrap;

  pwm_cfg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cfg(cfg), .period(period), .cmp(cmp)
  );

  pwm_pin_sync #(.N(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin({ext_trig, ext_clk}), .lvl(lvl), .lvl_d(lvl_d)
  );

  pwm_trig_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sw_start(cfg.sw_start), .sw_reset(cfg.sw_reset), .mask(cfg.mask),
    .str_pol(cfg.str_pol), .rst_pol(cfg.rst_pol),
    .str_src(cfg.str_src), .rst_src(cfg.rst_src),
    .pin_lvl(lvl[1]), .pin_lvl_d(lvl_d[1]),
    .run(run), .clr(clr)
  );

  assign tick = run & (cfg.clk_ext ? (lvl[0] & ~lvl_d[0]) : 1'b1);

  pwm_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr),
    .presc(cfg.presc), .wave(cfg.wave), .period(period), .cmp(cmp),
    .cnt(cnt_value), .pwm(pwm_out), .adv(adv), .wrap(wrap)
  );

endmodule

// File: rtl/pwm_trig_timer_chk.sv
module pwm_trig_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             clr,
  input logic             adv,
  input logic             wrap,
  input logic             mask,
  input logic             wave,
  input logic             pwm,
  input logic [CNT_W-1:0] cnt
);

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R7

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !run); // R10

  AST_MASK_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && run) |=> run); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap && !clr) |=> cnt == $past(cnt) + 1'b1); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !clr) |=> cnt == '0); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt)); // R7

  AST_SQUARE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wave && wrap && !clr) |=> (!wave || pwm != $past(pwm))); // R13

endmodule

bind pwm_trig_timer pwm_trig_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .adv(adv), .wrap(wrap),
  .mask(cfg.mask), .wave(cfg.wave), .pwm(pwm_out), .cnt(cnt_value)
);

// File: tb/sim_pwm_trig_timer.sv
`timescale 1ns/1ps
module sim_pwm_trig_timer;

  localparam logic [2:0] RA_MODE = 3'd0, RA_TRIG = 3'd1, RA_SW = 3'd2,
                         RA_PLO = 3'd3, RA_PHI = 3'd4, RA_CLO = 3'd5, RA_CHI = 3'd6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        ext_clk = 1'b0, ext_trig = 1'b0;
  logic        pwm_out;
  logic [15:0] cnt_value;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_trig_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_clk(ext_clk), .ext_trig(ext_trig),
    .pwm_out(pwm_out), .cnt_value(cnt_value)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    ext_trig = v;
    wait_n(6);
  endtask

  task automatic set_period(input logic [15:0] p);
    wr(RA_PLO, p[7:0]);
    wr(RA_PHI, p[15:8]);
  endtask

  // stop and clear through the software reset bit, all trigger options at 0
  task automatic restart();
    wr(RA_TRIG, 8'h00);
    wr(RA_SW, 8'h02);
    wr(RA_SW, 8'h00);
    wait_n(2);
  endtask

  task automatic t_reset_state();
    check(cnt_value == 0, "R1 count", cnt_value, 0);
    check(pwm_out == 0, "R1 pwm", pwm_out, 0);
    wait_n(10);
    check(cnt_value == 0, "R1 stopped", cnt_value, 0);
  endtask

  task automatic t_prescale();
    int c0;
    set_period(16'hFFFF);
    wr(RA_MODE, 8'h00);
    restart();
    wr(RA_SW, 8'h01);
    wait_n(3);
    c0 = cnt_value; wait_n(10);
    check(cnt_value - c0 == 10, "R2 p=0", cnt_value - c0, 10);
    wr(RA_MODE, 8'h02);
    wait_n(8);
    c0 = cnt_value; wait_n(16);
    check(cnt_value - c0 == 4, "R2 p=2", cnt_value - c0, 4);
    wr(RA_MODE, 8'h00);
    c0 = cnt_value; wait_n(300);
    check(cnt_value - c0 == 300, "R2 upper byte", cnt_value - c0, 300);
  endtask

  task automatic t_clamp();
    int c0;
    wr(RA_MODE, 8'h14);
    restart();
    wr(RA_SW, 8'h01);
    wait_n(5);
    c0 = cnt_value; wait_n(65536);
    check(cnt_value - c0 == 1, "R3 clamp to 16", cnt_value - c0, 1);
    wr(RA_MODE, 8'h00);
  endtask

  task automatic t_ext_clock();
    int c0;
    restart();
    wr(RA_TRIG, 8'h01);
    wr(RA_SW, 8'h01);
    wait_n(20);
    check(cnt_value == 0, "R4 system clock ignored", cnt_value, 0);
    c0 = cnt_value;
    for (int i = 0; i < 5; i++) begin
      ext_clk = 1'b1; wait_n(4);
      ext_clk = 1'b0; wait_n(4);
    end
    wait_n(4);
    check(cnt_value - c0 == 5, "R4 external ticks", cnt_value - c0, 5);
  endtask

  task automatic t_start_src();
    restart();
    wr(RA_TRIG, 8'h02);
    wr(RA_SW, 8'h01);
    wait_n(10);
    check(cnt_value == 0, "R5 sw start ignored in pin mode", cnt_value, 0);
    set_pin(1'b1);
    wait_n(5);
    check(cnt_value > 0, "R5 pin start", cnt_value, 1);
    restart();
    wr(RA_TRIG, 8'h22);
    wait_n(5);
    check(cnt_value == 0, "R6 idle before falling edge", cnt_value, 0);
    set_pin(1'b0);
    check(cnt_value > 0, "R6 falling starts", cnt_value, 1);
    restart();
    wr(RA_TRIG, 8'h06);
    set_pin(1'b1);
    set_pin(1'b0);
    check(cnt_value == 0, "R5 code 11 ignores pin", cnt_value, 0);
    wr(RA_SW, 8'h01);
    wait_n(5);
    check(cnt_value > 0, "R5 code 11 sw start", cnt_value, 1);
    restart();
    wr(RA_TRIG, 8'h04);
    set_pin(1'b1);
    check(cnt_value > 0, "R5 both via pin", cnt_value, 1);
    restart();
    wr(RA_TRIG, 8'h04);
    wr(RA_SW, 8'h01);
    wait_n(5);
    check(cnt_value > 0, "R5 both via sw", cnt_value, 1);
    set_pin(1'b0);
  endtask

  task automatic t_reset_src();
    int c0;
    restart();
    wr(RA_TRIG, 8'h08);
    wr(RA_SW, 8'h01);
    wait_n(5);
    c0 = cnt_value;
    wr(RA_SW, 8'h03);
    wait_n(5);
    check(cnt_value > c0, "R7 sw reset ignored in pin mode", cnt_value, c0 + 1);
    set_pin(1'b1);
    check(cnt_value > c0, "R7 rising ignored at pol 0", cnt_value, c0 + 1);
    set_pin(1'b0);
    check(cnt_value == 0, "R7 falling resets", cnt_value, 0);
    wait_n(10);
    check(cnt_value == 0, "R7 stopped after reset", cnt_value, 0);
    wr(RA_TRIG, 8'h48);
    wr(RA_SW, 8'h00);
    wr(RA_SW, 8'h01);
    wait_n(5);
    check(cnt_value > 0, "R8 restarted", cnt_value, 1);
    set_pin(1'b1);
    check(cnt_value == 0, "R8 rising resets", cnt_value, 0);
    set_pin(1'b0);
  endtask

  task automatic t_mask();
    int c0;
    restart();
    wr(RA_SW, 8'h01);
    wait_n(5);
    wr(RA_TRIG, 8'h80);
    c0 = cnt_value;
    wr(RA_SW, 8'h03);
    wait_n(5);
    check(cnt_value > c0, "R9 masked reset", cnt_value, c0 + 1);
    wr(RA_TRIG, 8'h00);
    wr(RA_SW, 8'h01);
    wr(RA_SW, 8'h03);
    wait_n(3);
    check(cnt_value == 0, "R9 unmasked reset", cnt_value, 0);
    wr(RA_TRIG, 8'h80);
    wr(RA_SW, 8'h00);
    wr(RA_SW, 8'h01);
    wait_n(10);
    check(cnt_value == 0, "R9 masked start", cnt_value, 0);
    wr(RA_TRIG, 8'h00);
  endtask

  task automatic t_collision();
    restart();
    wr(RA_SW, 8'h01);
    wait_n(5);
    wr(RA_SW, 8'h00);
    wr(RA_SW, 8'h03);
    wait_n(2);
    check(cnt_value == 0, "R10 reset wins", cnt_value, 0);
    wait_n(20);
    check(cnt_value == 0, "R10 stays stopped", cnt_value, 0);
  endtask

  task automatic t_wrap();
    int c0, mx;
    set_period(16'd4);
    restart();
    wr(RA_SW, 8'h01);
    wait_n(3);
    mx = 0;
    for (int i = 0; i < 30; i++) begin
      if (cnt_value > mx) mx = cnt_value;
      @(negedge clk);
    end
    check(mx == 4, "R11 top value", mx, 4);
    c0 = cnt_value; wait_n(5);
    check(cnt_value == c0, "R11 cycle of five", cnt_value, c0);
  endtask

  task automatic t_pulse();
    int bad, hi;
    set_period(16'd9);
    wr(RA_CLO, 8'd3); wr(RA_CHI, 8'd0);
    wr(RA_MODE, 8'h00);
    restart();
    wr(RA_SW, 8'h01);
    wait_n(3);
    bad = 0; hi = 0;
    for (int i = 0; i < 20; i++) begin
      if (pwm_out != (cnt_value < 3)) bad++;
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check(bad == 0, "R12 pulse vs compare", bad, 0);
    check(hi == 6, "R12 duty", hi, 6);
  endtask

  task automatic t_square();
    int bad, flips, pc;
    logic pp;
    set_period(16'd3);
    wr(RA_MODE, 8'h20);
    restart();
    check(pwm_out == 0, "R13 low after reset", pwm_out, 0);
    wr(RA_SW, 8'h01);
    wait_n(3);
    bad = 0; flips = 0;
    pc = cnt_value; pp = pwm_out;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pc == 3 && cnt_value == 0) begin
        if (pwm_out == pp) bad++; else flips++;
      end else if (pwm_out != pp) bad++;
      pc = cnt_value; pp = pwm_out;
    end
    check(bad == 0, "R13 toggle on wrap only", bad, 0);
    check(flips == 10, "R13 toggle count", flips, 10);
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    t_reset_state();
    t_prescale();
    t_clamp();
    t_ext_clock();
    t_start_src();
    t_reset_src();
    t_mask();
    t_collision();
    t_wrap();
    t_pulse();
    t_square();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #950000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule